// File: doc/BRIEF.md
# Miss-Rate Driven Replacement Policy Selector

This controller watches the hit and miss strobes of a GPU-side cache buffer and picks which of two replacement policies that buffer should use. Time is cut into fixed windows of `INTERVAL_CYCLES` clock cycles. At the end of each window the controller forms the window's miss ratio and compares it with a reference ratio that describes the preceding phase. If the new window missed proportionally more often, the policy in use is judged a poor fit and the mode bit flips to the other policy. A one-cycle pulse marks each flip.

The reference ratio starts at a default of `INIT_PCT` percent. Whenever the window keeps its policy, the reference becomes that window's own statistics. When the policy flips, the reference becomes the merged hit and miss totals of the two most recent windows, so that it spans the change of policy. A reference above `CEIL_PCT` percent is discarded and replaced by the default, which keeps the reference from drifting towards an unbeatable value. Ratios are never divided out: both sides are cross-multiplied and compared as integers. The replacement engines themselves live elsewhere and only read `policy_o`.

Top module: `mrps_policy_switch`

## Requirements
- R1: While reset is held and on the first cycle after it, `policy_o` is 0 (recency-only policy) and `switch_o` is 0.
- R2: A window is exactly `INTERVAL_CYCLES` cycles. The first window starts with the first rising edge at which reset is low. Its verdict appears on `switch_o` and `policy_o` in the cycle after the window's last edge.
- R3: A window whose miss ratio is strictly higher than the reference toggles `policy_o` (0 = recency-only, 1 = frequency-then-recency) and raises `switch_o` for that one cycle. An equal or lower ratio leaves both unchanged.
- R4: Until the first non-empty window has been judged, the reference ratio is `INIT_PCT` percent (80).
- R5: After a window that keeps its policy, the reference becomes that window's misses over its accesses. After a window that flips the policy, the reference becomes the misses summed over that window and the window before it, divided by the accesses summed over the same two windows.
- R6: If the reference from R5 exceeds `CEIL_PCT` percent (90), the default `INIT_PCT` is used instead.
- R7: A window with no hit or miss strobe causes no switch and leaves the reference and the stored last-window statistics untouched.
- R8: Strobes in a window's last cycle count towards that window. Each new window starts from zero counts.
- R9: A hit strobe and a miss strobe in the same cycle both count. Each counts as one access.
- R10: `switch_o` is high only in the cycle right after a window's last edge, never in two consecutive cycles, and `policy_o` changes only in a cycle in which `switch_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| hit_i | input | 1 | One buffer hit in this cycle |
| miss_i | input | 1 | One buffer miss in this cycle |
| policy_o | output | 1 | Selected replacement policy: 0 recency-only, 1 frequency-then-recency |
| switch_o | output | 1 | One-cycle pulse when `policy_o` changes |

## Verification
The bound checker watches, on every cycle, that pulses come only right after a window boundary and never twice in a row, that the policy bit moves exactly when a pulse is present, that an empty window never produces a pulse, and that reset leaves the outputs cleared. Whether a given window should have switched depends on the ratio arithmetic, the reference carried across flips, the ceiling rule and the counting of boundary strobes. Only the bench shows these: it sweeps every hit and miss count a short window can hold, places the strobes at the start or at the end of the window, and compares each verdict with a reference model that works from the requirement text.

// File: rtl/mrps_pkg.sv
package mrps_pkg;

    // Encoding of the policy selector bit seen by the replacement engines.
    typedef enum logic {
        POL_RECENCY      = 1'b0,
        POL_FREQ_RECENCY = 1'b1
    } policy_e;

    // Channel indices of the event tallies.
    localparam int unsigned CH_HIT  = 0;
    localparam int unsigned CH_MISS = 1;
    localparam int unsigned N_CH    = 2;

endpackage

// File: rtl/mrps_interval_timer.sv
module mrps_interval_timer #(
    parameter int unsigned INTERVAL_CYCLES = 100000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic last_o
);
    localparam int unsigned TW = (INTERVAL_CYCLES > 2) ? $clog2(INTERVAL_CYCLES) : 1;
    localparam logic [TW-1:0] LAST_IDX = TW'(INTERVAL_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == LAST_IDX) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last_o = (tmr_q.cnt == LAST_IDX);

endmodule

// File: rtl/mrps_event_tally.sv
module mrps_event_tally #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             strobe_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] total_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } tally_t;

    tally_t tally_d, tally_q;
    logic [CNT_W-1:0] running;

    // The running total includes the strobe of the current cycle, so a
    // strobe on the window's last cycle lands in the window that ends.
    assign running = tally_q.count + CNT_W'(strobe_i);

    always_comb begin
        tally_d = tally_q;
        if (clear_i) begin
            tally_d.count = '0;
        end else begin
            tally_d.count = running;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end

    assign total_o = running;

endmodule

// File: rtl/mrps_phase_judge.sv
module mrps_phase_judge
    import mrps_pkg::*;
#(
    parameter int unsigned CNT_W    = 17,
    parameter int unsigned INIT_PCT = 80,
    parameter int unsigned CEIL_PCT = 90
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             eval_i,
    input  logic [CNT_W-1:0] misses_i,
    input  logic [CNT_W-1:0] hits_i,
    output logic             policy_o,
    output logic             switch_o
);
    // One window holds up to 2*N accesses (hit and miss in one cycle).
    localparam int unsigned TOT_W = CNT_W + 1;
    // The reference spans two windows.
    localparam int unsigned PW    = CNT_W + 2;
    // Width for every cross product, with margin for the percent constants.
    localparam int unsigned MW    = 2 * PW + 8;

    typedef struct packed {
        policy_e           policy;
        logic              pulse;
        logic              use_dflt;
        logic [PW-1:0]     ref_miss;
        logic [PW-1:0]     ref_tot;
        logic [TOT_W-1:0]  last_miss;
        logic [TOT_W-1:0]  last_tot;
    } judge_t;

    judge_t jd_d, jd_q;

    logic [TOT_W-1:0] cur_tot;
    logic [MW-1:0]    lhs;
    logic [MW-1:0]    rhs;
    logic             worse;
    logic             active;
    logic             flip;
    logic [PW-1:0]    cand_miss;
    logic [PW-1:0]    cand_tot;
    logic [MW-1:0]    ceil_lhs;
    logic [MW-1:0]    ceil_rhs;
    logic             over_ceil;

    always_comb begin
        cur_tot = TOT_W'(misses_i) + TOT_W'(hits_i);

        // Compare misses/cur_tot with ref_miss/ref_tot without division.
        if (jd_q.use_dflt) begin
            lhs = MW'(misses_i) * MW'(100);
            rhs = MW'(INIT_PCT) * MW'(cur_tot);
        end else begin
            lhs = MW'(misses_i) * MW'(jd_q.ref_tot);
            rhs = MW'(jd_q.ref_miss) * MW'(cur_tot);
        end
        worse  = (lhs > rhs);
        active = eval_i && (cur_tot != '0);
        flip   = active && worse;

        // Candidate reference: this window alone, or merged with the
        // previous window when the policy changes across them.
        if (flip) begin
            cand_miss = PW'(jd_q.last_miss) + PW'(misses_i);
            cand_tot  = PW'(jd_q.last_tot) + PW'(cur_tot);
        end else begin
            cand_miss = PW'(misses_i);
            cand_tot  = PW'(cur_tot);
        end

        ceil_lhs  = MW'(cand_miss) * MW'(100);
        ceil_rhs  = MW'(CEIL_PCT) * MW'(cand_tot);
        over_ceil = (ceil_lhs > ceil_rhs);

        jd_d       = jd_q;
        jd_d.pulse = flip;
        if (active) begin
            if (flip) begin
                jd_d.policy = (jd_q.policy == POL_RECENCY) ? POL_FREQ_RECENCY : POL_RECENCY;
            end
            jd_d.ref_miss  = cand_miss;
            jd_d.ref_tot   = cand_tot;
            jd_d.use_dflt  = over_ceil;
            jd_d.last_miss = TOT_W'(misses_i);
            jd_d.last_tot  = cur_tot;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            jd_q          <= '0;
            jd_q.policy   <= POL_RECENCY;
            jd_q.use_dflt <= 1'b1;
        end else begin
            jd_q <= jd_d;
        end
    end

    assign policy_o = jd_q.policy;
    assign switch_o = jd_q.pulse;

endmodule

// File: rtl/mrps_policy_switch.sv
module mrps_policy_switch
    import mrps_pkg::*;
#(
    parameter int unsigned INTERVAL_CYCLES = 100000,
    parameter int unsigned INIT_PCT        = 80,
    parameter int unsigned CEIL_PCT        = 90
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic hit_i,
    input  logic miss_i,
    output logic policy_o,
    output logic switch_o
);
    localparam int unsigned CNT_W = $clog2(INTERVAL_CYCLES + 1);

    logic                      interval_end;
    logic [N_CH-1:0]           strobe_vec;
    logic [N_CH-1:0][CNT_W-1:0] tally_total;
    logic [CNT_W-1:0]          hit_cnt;
    logic [CNT_W-1:0]          miss_cnt;

    assign strobe_vec[CH_HIT]  = hit_i;
    assign strobe_vec[CH_MISS] = miss_i;

    mrps_interval_timer #(
        .INTERVAL_CYCLES(INTERVAL_CYCLES)
    ) u_timer (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .last_o(interval_end)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_tally
        mrps_event_tally #(
            .CNT_W(CNT_W)
        ) u_tally (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .strobe_i(strobe_vec[ch]),
            .clear_i (interval_end),
            .total_o (tally_total[ch])
        );
    end

    assign hit_cnt  = tally_total[CH_HIT];
    assign miss_cnt = tally_total[CH_MISS];

    mrps_phase_judge #(
        .CNT_W   (CNT_W),
        .INIT_PCT(INIT_PCT),
        .CEIL_PCT(CEIL_PCT)
    ) u_judge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .eval_i  (interval_end),
        .misses_i(miss_cnt),
        .hits_i  (hit_cnt),
        .policy_o(policy_o),
        .switch_o(switch_o)
    );

endmodule

// File: rtl/mrps_policy_switch_chk.sv
module mrps_policy_switch_chk #(
    parameter int unsigned CNT_W = 17
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             policy_o,
    input logic             switch_o,
    input logic             boundary,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt
);

    // R1
    reset_clears_outputs_chk: assert property (@(posedge clk_i)
        rst_i |=> (!policy_o && !switch_o))
        else $error("outputs not cleared by reset");

    // R10
    pulse_after_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(switch_o) |-> $past(boundary))
        else $error("switch pulse away from window boundary");

    // R10
    pulse_single_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        switch_o |=> !switch_o)
        else $error("switch pulse longer than one cycle");

    // R10
    policy_moves_with_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (policy_o != $past(policy_o)) |-> switch_o)
        else $error("policy changed without pulse");

    // R3
    pulse_flips_policy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        switch_o |-> (policy_o != $past(policy_o)))
        else $error("pulse without policy change");

    // R7
    empty_window_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (boundary && hit_cnt == '0 && miss_cnt == '0) |=> !switch_o)
        else $error("empty window produced a switch");

endmodule

bind mrps_policy_switch mrps_policy_switch_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .policy_o(policy_o),
    .switch_o(switch_o),
    .boundary(interval_end),
    .hit_cnt (hit_cnt),
    .miss_cnt(miss_cnt)
);

// File: tb/mrps_policy_switch_test.sv
module mrps_policy_switch_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit = 1'b0;
    logic miss = 1'b0;
    logic policy;
    logic sw;

    int checks = 0;
    int fails  = 0;

    // Reference model state (from the requirement text).
    int     e_policy = 0;
    bit     e_dflt   = 1'b1;
    longint r_miss   = 0;
    longint r_tot    = 0;
    longint l_miss   = 0;
    longint l_tot    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mrps_policy_switch #(
        .INTERVAL_CYCLES(N),
        .INIT_PCT       (80),
        .CEIL_PCT       (90)
    ) uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .hit_i   (hit),
        .miss_i  (miss),
        .policy_o(policy),
        .switch_o(sw)
    );

    task automatic check(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Drives one window with m misses and h hits, at its start or at its end,
    // then checks the verdict in the cycle after the window's last edge.
    task automatic run_window(input int m, input int h, input bit tail, input string req);
        longint t;
        bit     exp_sw;
        longint cm;
        longint ct;
        for (int c = 0; c < N; c++) begin
            miss = tail ? (c >= N - m) : (c < m);
            hit  = tail ? (c >= N - h) : (c < h);
            @(negedge clk);
            if (c == N / 2) begin
                check($sformatf("R10 %s mid-window pulse m=%0d h=%0d", req, m, h), sw, 0);
                check($sformatf("R10 %s mid-window policy m=%0d h=%0d", req, m, h), policy, e_policy);
            end
        end
        miss = 1'b0;
        hit  = 1'b0;
        t      = m + h;
        exp_sw = 1'b0;
        if (t > 0) begin
            if (e_dflt) exp_sw = (m * 100 > 80 * t);
            else        exp_sw = (m * r_tot > r_miss * t);
            if (exp_sw) begin
                cm = l_miss + m;
                ct = l_tot + t;
            end else begin
                cm = m;
                ct = t;
            end
            e_dflt = (cm * 100 > 90 * ct);
            r_miss = cm;
            r_tot  = ct;
            l_miss = m;
            l_tot  = t;
            if (exp_sw) e_policy = 1 - e_policy;
        end
        check($sformatf("%s switch m=%0d h=%0d tail=%0d", req, m, h, tail), sw, exp_sw);
        check($sformatf("%s policy m=%0d h=%0d tail=%0d", req, m, h, tail), policy, e_policy);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 policy in reset", policy, 0);
        check("R1 pulse in reset", sw, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 policy after reset", policy, 0);
        check("R1 pulse after reset", sw, 0);
        // Restart window alignment: one cycle already elapsed.
        // Run the remainder of the first window empty (R7 keeps it inert).
        repeat (N - 1) @(negedge clk);
        check("R7 empty first window pulse", sw, 0);

        run_window(4, 1, 1'b0, "R4 equal to default");
        run_window(0, 0, 1'b0, "R7 empty window");
        run_window(5, 3, 1'b0, "R3 lower ratio");
        run_window(6, 2, 1'b0, "R5 higher ratio");
        run_window(8, 0, 1'b1, "R5 merged reference");
        run_window(8, 0, 1'b0, "R6 ceiling");
        run_window(7, 1, 1'b0, "R6 default after ceiling");
        run_window(1, 0, 1'b1, "R8 last-cycle miss");
        run_window(0, 1, 1'b1, "R8 last-cycle hit");
        run_window(8, 8, 1'b0, "R9 coincident strobes");
        run_window(3, 8, 1'b1, "R9 coincident at end");

        for (int m = 0; m <= N; m++) begin
            for (int h = 0; h <= N; h++) begin
                run_window(m, h, ((m + h) % 2) == 1, "R2 sweep");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule